// File: doc/BRIEF.md
# Greedy-then-Oldest Warp Issue Scheduler

This block picks, in every cycle, at most one warp from a fixed pool of `NUM_WARPS` warps to send to the issue stage. A warp is a candidate when it reports ready and is not stalled. The block has two policies. In rotating mode, the choice moves round the pool so that successive issues come from different warps. In greedy mode, the block stays on the warp it picked last for as long as that warp can still issue. When that warp drops out, the block turns to the oldest candidate. Age is fixed by position: a lower warp index means an older warp.

A load throttle works alongside either policy. Only warps whose index is below a cap may issue an instruction whose next operation is a memory load. This bounds how many warps share the L1 cache at once. Warps at or above the cap may still issue any instruction that is not a load. The cap and the policy select are control pins. They are captured only in cycles where nothing issues, so a change never lands in the middle of a decision. The grant is combinational from the current inputs and the captured state. Every port is a plain control or status pin; the block has no valid/ready stream and no back-pressure path.

Top module: `wsched_top`

## Requirements
- R1: While reset is held, and in any cycle where no warp is a candidate, `issue_o` is 0 and `grant_o` is all zeros. Reset leaves the block in rotating mode with the cap equal to `NUM_WARPS`, and with no warp remembered as the last one issued.
- R2: When `issue_o` is 1, `grant_o` has exactly one bit set, at bit position `warp_o`.
- R3: A warp is a candidate only when its `ready_i` bit is 1 and its `stall_i` bit is 0. No other warp is ever granted.
- R4: In rotating mode (`mode_i` = 0), the grant goes to the first candidate found by searching upward from the last issued index and wrapping from `NUM_WARPS-1` to 0. After reset, the search begins at warp 0.
- R5: In rotating mode, when the last issued warp is the only candidate, it is granted again.
- R6: In greedy mode (`mode_i` = 1), if the last issued warp is still a candidate, it is granted again.
- R7: In greedy mode, if the last issued warp is not a candidate, the candidate with the lowest index is granted.
- R8: In greedy mode, when no warp has issued since reset, the candidate with the lowest index is granted.
- R9: A warp whose `load_i` bit is 1 is a candidate only if its index is less than the captured cap. A cap of 0 blocks every load.
- R10: A warp whose `load_i` bit is 0 is not affected by the cap.
- R11: In a cycle with no issue, the last-issued pointer keeps its value. Selection in later cycles carries on from that pointer.
- R12: `mode_i` and `cap_i` are captured only at the end of a cycle in which `issue_o` is 0. Their values in an issuing cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | Policy select: 0 = rotating, 1 = greedy-then-oldest |
| cap_i | input | $clog2(NUM_WARPS+1) | Number of warps that may issue loads, counted from index 0 |
| ready_i | input | NUM_WARPS | Warp has an instruction ready |
| stall_i | input | NUM_WARPS | Warp is stalled and cannot issue |
| load_i | input | NUM_WARPS | The warp's next instruction is a memory load |
| grant_o | output | NUM_WARPS | One-hot issue grant |
| warp_o | output | $clog2(NUM_WARPS) | Index of the granted warp |
| issue_o | output | 1 | A warp is granted this cycle |

## Verification
The bench builds the block with `NUM_WARPS` = 4, so the cap is 3 bits wide and the warp index is 2 bits wide. With a pool this small, a short vector table can reach the rotating search's wrap from warp 3 to warp 0, the single-candidate repeat, and the greedy hold and fallback. It also reaches the cap values 0, 2 and 4, which cover blocked loads, partly allowed loads and an open throttle. Directed steps cover the reset state and the greedy start when no pointer is held. They also show that mode and cap changes made during issuing cycles have no effect.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  typedef enum logic {
    SCHED_ROTATE = 1'b0,
    SCHED_GREEDY = 1'b1
  } sched_mode_e;
endpackage

// File: rtl/wsched_elig.sv
module wsched_elig #(
  parameter int NUM_WARPS = 4,
  parameter int CAP_W     = $clog2(NUM_WARPS + 1)
) (
  input  logic [NUM_WARPS-1:0] ready_i,
  input  logic [NUM_WARPS-1:0] stall_i,
  input  logic [NUM_WARPS-1:0] load_i,
  input  logic [CAP_W-1:0]     cap_i,
  output logic [NUM_WARPS-1:0] elig_o
);
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic load_ok;
    assign load_ok   = (32'(w) < 32'(cap_i));
    assign elig_o[w] = ready_i[w] & ~stall_i[w] & (~load_i[w] | load_ok);
  end

  // R3
  always_comb begin
    stall_block_chk: assert ((elig_o & (stall_i | ~ready_i)) == '0);
  end
endmodule

// File: rtl/wsched_pick.sv
module wsched_pick
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 4,
  parameter int IDX_W     = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic [NUM_WARPS-1:0] elig_i,
  input  sched_mode_e          mode_i,
  input  logic [IDX_W-1:0]     last_i,
  input  logic                 last_vld_i,
  output logic [NUM_WARPS-1:0] grant_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic                 valid_o
);
  logic [IDX_W-1:0] oldest_idx;
  logic             oldest_hit;
  logic [IDX_W-1:0] rot_idx;
  logic             rot_hit;
  int               rot_base;

  // lowest index wins: that is the oldest warp
  always_comb begin
    oldest_idx = '0;
    oldest_hit = 1'b0;
    for (int w = NUM_WARPS - 1; w >= 0; w--) begin
      if (elig_i[w]) begin
        oldest_idx = IDX_W'(w);
        oldest_hit = 1'b1;
      end
    end
  end

  // rotating search upward from the last issued warp, wrapping round
  always_comb begin
    rot_base = last_vld_i ? int'(last_i) : NUM_WARPS - 1;
    rot_idx  = '0;
    rot_hit  = 1'b0;
    for (int k = NUM_WARPS; k >= 1; k--) begin
      int cand;
      cand = (rot_base + k) % NUM_WARPS;
      if (elig_i[cand]) begin
        rot_idx = IDX_W'(cand);
        rot_hit = 1'b1;
      end
    end
  end

  always_comb begin
    if (mode_i == SCHED_GREEDY) begin
      if (last_vld_i && elig_i[last_i]) begin
        idx_o   = last_i;
        valid_o = 1'b1;
      end else begin
        idx_o   = oldest_idx;
        valid_o = oldest_hit;
      end
    end else begin
      idx_o   = rot_idx;
      valid_o = rot_hit;
    end
    grant_o = valid_o ? (NUM_WARPS'(1) << idx_o) : '0;
  end

  // R2
  always_comb begin
    grant_onehot_chk: assert ($onehot0(grant_o) && (valid_o == (grant_o != '0)));
  end
endmodule

// File: rtl/wsched_top.sv
module wsched_top
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 4,
  localparam int CAP_W    = $clog2(NUM_WARPS + 1),
  localparam int IDX_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_i,
  input  logic [CAP_W-1:0]     cap_i,
  input  logic [NUM_WARPS-1:0] ready_i,
  input  logic [NUM_WARPS-1:0] stall_i,
  input  logic [NUM_WARPS-1:0] load_i,
  output logic [NUM_WARPS-1:0] grant_o,
  output logic [IDX_W-1:0]     warp_o,
  output logic                 issue_o
);
  sched_mode_e          mode_r;
  logic [CAP_W-1:0]     cap_r;
  logic [IDX_W-1:0]     last_r;
  logic                 last_vld_r;
  logic [NUM_WARPS-1:0] elig;
  logic [NUM_WARPS-1:0] pick_grant;
  logic [IDX_W-1:0]     pick_idx;
  logic                 pick_valid;

  wsched_elig #(.NUM_WARPS(NUM_WARPS), .CAP_W(CAP_W)) u_elig (
    .ready_i (ready_i),
    .stall_i (stall_i),
    .load_i  (load_i),
    .cap_i   (cap_r),
    .elig_o  (elig)
  );

  wsched_pick #(.NUM_WARPS(NUM_WARPS), .IDX_W(IDX_W)) u_pick (
    .elig_i     (elig),
    .mode_i     (mode_r),
    .last_i     (last_r),
    .last_vld_i (last_vld_r),
    .grant_o    (pick_grant),
    .idx_o      (pick_idx),
    .valid_o    (pick_valid)
  );

  assign grant_o = rst_ni ? pick_grant : '0;
  assign warp_o  = pick_idx;
  assign issue_o = rst_ni & pick_valid;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mode_r     <= SCHED_ROTATE;
      cap_r      <= CAP_W'(NUM_WARPS);
      last_r     <= '0;
      last_vld_r <= 1'b0;
    end else if (issue_o) begin
      last_r     <= warp_o;
      last_vld_r <= 1'b1;
    end else begin
      mode_r <= sched_mode_e'(mode_i);
      cap_r  <= cap_i;
    end
  end

  // R11
  hold_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_o |=> (last_r == $past(last_r)) && (last_vld_r == $past(last_vld_r)));

  // R12
  cfg_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |=> (mode_r == $past(mode_r)) && (cap_r == $past(cap_r)));

  // R6
  greedy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && mode_r == SCHED_GREEDY) |=> (!elig[$past(warp_o)] || warp_o == $past(warp_o)));

  // R4
  rotate_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && mode_r == SCHED_ROTATE && last_vld_r && $countones(elig) > 1) |-> warp_o != last_r);

  // R9
  load_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && load_i[warp_o]) |-> (32'(warp_o) < 32'(cap_r)));

  // R3
  grant_elig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> (ready_i[warp_o] && !stall_i[warp_o]));
endmodule

// File: tb/wsched_top_bench.sv
`timescale 1ns/1ps
module wsched_top_bench;
  localparam int NW = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0;
  logic [2:0] cap = 3'd4;
  logic [3:0] ready = '0, stall = '0, load = '0;
  logic [3:0] grant;
  logic [1:0] warp;
  logic       issue;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2.5 clk = ~clk;

  wsched_top #(.NUM_WARPS(NW)) u_wsched_top (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cap_i(cap),
    .ready_i(ready), .stall_i(stall), .load_i(load),
    .grant_o(grant), .warp_o(warp), .issue_o(issue)
  );

  // row: mode, cap, ready, stall, load, expected issue, expected index
  localparam int ROWS = 20;
  localparam logic [18:0] TBL [ROWS] = '{
    {1'b0, 3'd4, 4'b1111, 4'b0000, 4'b0000, 1'b1, 2'd0},
    {1'b0, 3'd4, 4'b1111, 4'b0000, 4'b0000, 1'b1, 2'd1},
    {1'b0, 3'd4, 4'b1111, 4'b0000, 4'b0000, 1'b1, 2'd2},
    {1'b0, 3'd4, 4'b1011, 4'b0000, 4'b0000, 1'b1, 2'd3},
    {1'b0, 3'd4, 4'b0110, 4'b0000, 4'b0000, 1'b1, 2'd1},
    {1'b0, 3'd4, 4'b0010, 4'b0000, 4'b0000, 1'b1, 2'd1},
    {1'b1, 3'd4, 4'b0010, 4'b0010, 4'b0000, 1'b0, 2'd0},
    {1'b1, 3'd4, 4'b1111, 4'b0000, 4'b0000, 1'b1, 2'd1},
    {1'b0, 3'd4, 4'b1111, 4'b0000, 4'b0000, 1'b1, 2'd1},
    {1'b1, 3'd4, 4'b1111, 4'b0010, 4'b0000, 1'b1, 2'd0},
    {1'b1, 3'd4, 4'b1110, 4'b0000, 4'b0000, 1'b1, 2'd1},
    {1'b1, 3'd2, 4'b1100, 4'b0000, 4'b1100, 1'b1, 2'd2},
    {1'b1, 3'd2, 4'b0000, 4'b0000, 4'b0000, 1'b0, 2'd0},
    {1'b1, 3'd2, 4'b1100, 4'b0000, 4'b1100, 1'b0, 2'd0},
    {1'b1, 3'd2, 4'b1100, 4'b0000, 4'b0100, 1'b1, 2'd3},
    {1'b1, 3'd2, 4'b0011, 4'b0000, 4'b0011, 1'b1, 2'd0},
    {1'b0, 3'd0, 4'b0000, 4'b0000, 4'b0000, 1'b0, 2'd0},
    {1'b0, 3'd0, 4'b0011, 4'b0000, 4'b0011, 1'b0, 2'd0},
    {1'b0, 3'd0, 4'b0011, 4'b0000, 4'b0001, 1'b1, 2'd1},
    {1'b0, 3'd0, 4'b0011, 4'b0000, 4'b0000, 1'b1, 2'd0}
  };
  localparam string TAGS [ROWS] = '{
    "R4", "R4", "R4", "R4", "R4 wrap", "R5", "R3 R11", "R6", "R12", "R7",
    "R7", "R12", "R1", "R9", "R10", "R9", "R1", "R9", "R10", "R4 R11"
  };

  task automatic check(input string req, input logic ev, input logic [1:0] ei);
    logic [3:0] eg;
    logic       bad;
    eg  = ev ? (4'b0001 << ei) : 4'b0000;
    bad = (issue !== ev) || (grant !== eg) || (ev && warp !== ei);
    n_chk++;
    if (bad) begin
      n_bad++;
      $display("FAIL %s: issue=%0b grant=%b warp=%0d, expected issue=%0b grant=%b warp=%0d",
               req, issue, grant, warp, ev, eg, ei);
    end
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    ready = 4'b1111;
    #1 check("R1 in reset", 1'b0, 2'd0);
    ready = '0;
    @(negedge clk);
    #1 check("R1 reset idle", 1'b0, 2'd0);
    rst_n = 1'b1;

    for (int i = 0; i < ROWS; i++) begin
      @(negedge clk);
      {mode, cap, ready, stall, load} = TBL[i][18:3];
      #1 check($sformatf("%s row %0d", TAGS[i], i), TBL[i][2], TBL[i][1:0]);
    end

    // R8: greedy start with no remembered warp after reset
    @(negedge clk);
    rst_n = 1'b0; ready = '0; stall = '0; load = '0; cap = 3'd4;
    @(negedge clk);
    rst_n = 1'b1; mode = 1'b1;
    #1 check("R1 idle after reset", 1'b0, 2'd0);
    @(negedge clk);
    ready = 4'b1100;
    #1 check("R8 greedy oldest", 1'b1, 2'd2);
    @(negedge clk);
    #1 check("R6 greedy keeps", 1'b1, 2'd2);

    // R2: grant bit follows index across all warps in rotation
    @(negedge clk);
    ready = '0; mode = 1'b0;
    #1 check("R11 idle", 1'b0, 2'd0);
    for (int w = 0; w < NW; w++) begin
      @(negedge clk);
      ready = 4'b1111;
      #1 check("R2 rotate", 1'b1, 2'((w + 3) % NW));
    end

    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule